// File: doc/BRIEF.md
# Dual-Processor Hardware Lock Gates

This block holds sixteen hardware lock gates that two processors use to guard shared resources. Each gate is a tiny state machine that is either free or owned by one of the two processors. A processor takes a gate by writing its own owner code to the gate's byte, and gives it back by writing zero. The hardware makes the test-and-set atomic, so no software spin protocol is needed to decide who won.

Each processor has its own request port on a simple register bus, with byte, halfword and word accesses. One read can return several gates at once. A wide write is allowed only if it changes a single gate. A write that would change more than one gate returns an error and changes nothing.

A processor that fails to take a gate can go on with other work instead of spinning. The block remembers the failed attempt. When the owner frees that gate, it raises a per-processor request bit. An interrupt line, gated by a per-processor enable mask, then tells the waiting processor to retry.

Top module: `sema_gate_bank`

## Requirements
- R1: Each gate holds a 2-bit code: 00 free, 01 owned by processor 0, 10 owned by processor 1. Code 11 is never entered. Gate g lives at byte address g (0x00 to 0x0F), in bits 1:0 of its byte, and bits 7:2 of that byte read as zero.
- R2: Only bits 1:0 of a write byte are decoded. The own code (01 from port 0, 10 from port 1) takes the gate only if it is free. 00 frees the gate only when it comes from the current owner. Every other value, 11 included, and the other processor's code leave the gate unchanged, with no error.
- R3: A read returns, little-endian, the byte of every gate it covers: byte lane k is data bits 8k+7:8k. Lanes outside the access read as zero. bus_size encodes 0 = byte, 1 = halfword, 2 = word.
- R4: A halfword or word write to the gate area that would change at most one gate is accepted. One that would change two or more gates sets rsp_err and changes no gate.
- R5: A misaligned access, a bus_size of 3, or a byte access to a notification register sets rsp_err and has no effect.
- R6: After reset every gate is free, all enable and request bits are zero, and irq is low.
- R7: The notification-enable register for processor p is at 0x40 + 8p. Bit g enables gate g. It is written by an aligned halfword or word access, and bits 31:16 read as zero and ignore writes.
- R8: A lock attempt that fails because the other processor owns the gate is remembered. When that gate is freed, bit g of the requesting processor's notification-request register (0x80 + 8p) is set.
- R9: irq[p] is high exactly when some request bit of processor p is set and its enable bit is set.
- R10: A request bit clears when its processor takes that gate, or when a 1 is written to that bit of the request register.
- R11: If both processors write their own code to the same free gate in one cycle, processor 0 takes it, and processor 1's attempt counts as failed for R8.
- R12: rsp_valid, rsp_rdata and rsp_err appear on the cycle after the request. Gate, enable, request and irq changes are visible from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 2 | Access request, one bit per processor port |
| bus_we | input | 2 | Write when 1, read when 0, per port |
| bus_addr | input | 2x8 | Byte address per port |
| bus_size | input | 2x2 | Access size per port: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 2x32 | Write data per port, little-endian lanes |
| rsp_valid | output | 2 | Response valid, one cycle after the request |
| rsp_rdata | output | 2x32 | Read data per port |
| rsp_err | output | 2 | Error response per port |
| irq | output | 2 | Notification interrupt per processor |

## Verification
Every result of this block is due on the first rising edge after the request cycle. That covers the response, the new gate code, a new request bit and irq. The bench drives each request on a falling edge and samples 1 ns after the next rising edge. It reads gates and registers back with a separate access. The near-exhaustive sweep runs every gate through every start state, port and written code. Directed sequences then cover wide reads and writes, error cases, notification set and clear, and same-cycle contention, each at that one-cycle point.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int NPROC  = 2;

  typedef enum logic [1:0] {
    GATE_FREE = 2'b00,
    GATE_P0   = 2'b01,
    GATE_P1   = 2'b10,
    GATE_RSVD = 2'b11
  } gate_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_t;
endpackage

// File: rtl/sema_rst_sync.sv
module sema_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sema_port_decode.sv
module sema_port_decode
  import sema_pkg::*;
#(
  parameter int              NUM_GATES  = 16,
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] INE_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] NTF_BASE = 8'h80,
  parameter int              REG_STRIDE = 8,
  parameter bit              PROC_ID    = 1'b0
) (
  input  logic                            req,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [1:0]                      size,
  input  logic [BUS_W-1:0]                wdata,
  input  logic [NUM_GATES-1:0][1:0]       gate_state,
  input  logic [NPROC-1:0][NUM_GATES-1:0] ine,
  input  logic [NPROC-1:0][NUM_GATES-1:0] ntf,
  output logic [NUM_GATES-1:0]            lock_req,
  output logic [NUM_GATES-1:0]            unlock_req,
  output logic [NPROC-1:0]                ine_we,
  output logic [NPROC-1:0]                ntf_clr_we,
  output logic [NUM_GATES-1:0]            reg_wdata,
  output logic                            err,
  output logic [BUS_W-1:0]                rdata
);
  localparam int WIDX_W = ADDR_W - LANE_W;
  localparam logic [1:0] OWN = PROC_ID ? GATE_P1 : GATE_P0;

  logic [WIDX_W-1:0]    widx;
  logic [LANE_W-1:0]    lane;
  logic [LANES-1:0]     lmask;
  logic                 aligned;
  logic [NUM_GATES-1:0] lock_try, unlock_try, would_change;
  logic [NPROC-1:0]     ine_hit, ntf_hit;
  logic                 reg_area, multi_change, low_half;
  logic [BUS_W-1:0]     rword;

  assign widx = addr[ADDR_W-1:LANE_W];
  assign lane = addr[LANE_W-1:0];

  // size / alignment decode
  always_comb begin
    lmask   = '0;
    aligned = 1'b0;
    unique case (acc_size_t'(size))
      SZ_BYTE: begin lmask = LANES'(1) << lane; aligned = 1'b1;        end
      SZ_HALF: begin lmask = LANES'(3) << lane; aligned = ~addr[0];    end
      SZ_WORD: begin lmask = '1;                aligned = (lane == '0); end
      default: begin lmask = '0;                aligned = 1'b0;        end
    endcase
  end

  // per-gate write intent
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    localparam int GW = g / LANES;
    localparam int GL = g % LANES;
    logic       covered;
    logic [1:0] code;
    assign covered         = (widx == WIDX_W'(GW)) && lmask[GL];
    assign code            = wdata[8*GL +: 2];
    assign lock_try[g]     = req & we & covered & (code == OWN);
    assign unlock_try[g]   = req & we & covered & (code == GATE_FREE);
    assign would_change[g] = (lock_try[g]   & (gate_state[g] == GATE_FREE)) |
                             (unlock_try[g] & (gate_state[g] == OWN));
  end

  // register area hits
  for (genvar q = 0; q < NPROC; q++) begin : g_reg
    localparam logic [WIDX_W-1:0] IW = WIDX_W'((int'(INE_BASE) + REG_STRIDE*q) / LANES);
    localparam logic [WIDX_W-1:0] NW = WIDX_W'((int'(NTF_BASE) + REG_STRIDE*q) / LANES);
    assign ine_hit[q] = (widx == IW);
    assign ntf_hit[q] = (widx == NW);
  end

  assign reg_area     = |ine_hit | |ntf_hit;
  assign multi_change = ($countones(would_change) > 1);
  assign low_half     = lmask[0] & lmask[1];

  assign err = req & (~aligned |
                      (reg_area & (size == SZ_BYTE)) |
                      (we & (size != SZ_BYTE) & multi_change));

  assign lock_req   = lock_try   & {NUM_GATES{~err}};
  assign unlock_req = unlock_try & {NUM_GATES{~err}};
  assign ine_we     = ine_hit & {NPROC{req & we & ~err & low_half}};
  assign ntf_clr_we = ntf_hit & {NPROC{req & we & ~err & low_half}};
  assign reg_wdata  = wdata[NUM_GATES-1:0];

  // read data
  always_comb begin
    rword = '0;
    for (int g = 0; g < NUM_GATES; g++) begin
      if (widx == WIDX_W'(g / LANES)) rword[8*(g % LANES) +: 8] = 8'(gate_state[g]);
    end
    for (int q = 0; q < NPROC; q++) begin
      if (ine_hit[q]) rword[15:0] = 16'(ine[q]);
      if (ntf_hit[q]) rword[15:0] = 16'(ntf[q]);
    end
    for (int k = 0; k < LANES; k++) begin
      if (!lmask[k]) rword[8*k +: 8] = 8'h00;
    end
    if (!req || we || err) rword = '0;
  end

  assign rdata = rword;
endmodule

// File: rtl/sema_gate_fsm.sv
module sema_gate_fsm
  import sema_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] lock_req,
  input  logic [NPROC-1:0] unlock_req,
  output logic [1:0]       state,
  output logic [NPROC-1:0] fail,
  output logic [NPROC-1:0] acquired,
  output logic             released
);
  gate_t state_q, state_d;
  logic  en;

  always_comb begin
    state_d = state_q;
    fail    = '0;
    unique case (state_q)
      GATE_FREE: begin
        if (lock_req[0])      state_d = GATE_P0;
        else if (lock_req[1]) state_d = GATE_P1;
        fail[1] = lock_req[0] & lock_req[1];
      end
      GATE_P0: begin
        if (unlock_req[0]) state_d = GATE_FREE;
        fail[1] = lock_req[1];
      end
      GATE_P1: begin
        if (unlock_req[1]) state_d = GATE_FREE;
        fail[0] = lock_req[0];
      end
      default: state_d = GATE_FREE;
    endcase
  end

  assign en          = |lock_req | |unlock_req;
  assign released    = (state_q != GATE_FREE) && (state_d == GATE_FREE);
  assign acquired[0] = (state_q == GATE_FREE) && (state_d == GATE_P0);
  assign acquired[1] = (state_q == GATE_FREE) && (state_d == GATE_P1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= GATE_FREE;
    else if (en) state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sema_notify.sv
module sema_notify #(
  parameter int NUM_GATES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_GATES-1:0] fail,
  input  logic [NUM_GATES-1:0] released,
  input  logic [NUM_GATES-1:0] acquired,
  input  logic                 ine_we,
  input  logic [NUM_GATES-1:0] ine_wdata,
  input  logic [NUM_GATES-1:0] clr_mask,
  output logic [NUM_GATES-1:0] ine,
  output logic [NUM_GATES-1:0] ntf,
  output logic                 irq
);
  logic [NUM_GATES-1:0] pend_q, pend_d, ntf_q, ntf_d, ine_q, ine_d, ntf_set;
  logic                 pend_en, ntf_en;

  always_comb begin
    ntf_set = released & (pend_q | fail);
    pend_d  = (pend_q | fail) & ~released & ~acquired;
    ntf_d   = (ntf_q & ~clr_mask & ~acquired) | ntf_set;
    ine_d   = ine_wdata;
    pend_en = |fail | |released | |acquired;
    ntf_en  = |clr_mask | |acquired | |ntf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ntf_q  <= '0;
      ine_q  <= '0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (ntf_en)  ntf_q  <= ntf_d;
      if (ine_we)  ine_q  <= ine_d;
    end
  end

  assign ine = ine_q;
  assign ntf = ntf_q;
  assign irq = |(ntf_q & ine_q);
endmodule

// File: rtl/sema_gate_bank.sv
module sema_gate_bank
  import sema_pkg::*;
#(
  parameter int              NUM_GATES  = 16,
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] INE_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] NTF_BASE = 8'h80,
  parameter int              REG_STRIDE = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   bus_req,
  input  logic [1:0]                   bus_we,
  input  logic [1:0][ADDR_W-1:0]       bus_addr,
  input  logic [1:0][1:0]              bus_size,
  input  logic [1:0][31:0]             bus_wdata,
  output logic [1:0]                   rsp_valid,
  output logic [1:0][31:0]             rsp_rdata,
  output logic [1:0]                   rsp_err,
  output logic [1:0]                   irq
);
  logic rst_n_int;

  logic [NUM_GATES-1:0][1:0]              gate_state;
  logic [NPROC-1:0][NUM_GATES-1:0]        ine, ntf;
  logic [NPROC-1:0][NUM_GATES-1:0]        lock_pg, unlock_pg;
  logic [NPROC-1:0][NUM_GATES-1:0]        fail_pg, acq_pg;
  logic [NUM_GATES-1:0]                   released;
  logic [NPROC-1:0][NPROC-1:0]            ine_we_pq, clr_we_pq;
  logic [NPROC-1:0][NUM_GATES-1:0]        reg_wdata;
  logic [NPROC-1:0]                       err_c;
  logic [NPROC-1:0][31:0]                 rdata_c;

  sema_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_int)
  );

  for (genvar p = 0; p < NPROC; p++) begin : g_port
    sema_port_decode #(
      .NUM_GATES(NUM_GATES), .ADDR_W(ADDR_W), .INE_BASE(INE_BASE),
      .NTF_BASE(NTF_BASE), .REG_STRIDE(REG_STRIDE), .PROC_ID(p[0])
    ) u_dec (
      .req(bus_req[p]), .we(bus_we[p]), .addr(bus_addr[p]), .size(bus_size[p]),
      .wdata(bus_wdata[p]), .gate_state(gate_state), .ine(ine), .ntf(ntf),
      .lock_req(lock_pg[p]), .unlock_req(unlock_pg[p]),
      .ine_we(ine_we_pq[p]), .ntf_clr_we(clr_we_pq[p]),
      .reg_wdata(reg_wdata[p]), .err(err_c[p]), .rdata(rdata_c[p])
    );
  end

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic [NPROC-1:0] fail_g, acq_g;
    sema_gate_fsm u_fsm (
      .clk(clk), .rst_n(rst_n_int),
      .lock_req({lock_pg[1][g], lock_pg[0][g]}),
      .unlock_req({unlock_pg[1][g], unlock_pg[0][g]}),
      .state(gate_state[g]), .fail(fail_g), .acquired(acq_g),
      .released(released[g])
    );
    for (genvar p = 0; p < NPROC; p++) begin : g_tp
      assign fail_pg[p][g] = fail_g[p];
      assign acq_pg[p][g]  = acq_g[p];
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : g_ntf
    logic                 ine_we_any;
    logic [NUM_GATES-1:0] ine_wd, clr_mask;
    // port 0 wins a same-cycle enable write; clear masks merge
    assign ine_we_any = ine_we_pq[0][p] | ine_we_pq[1][p];
    assign ine_wd     = ine_we_pq[0][p] ? reg_wdata[0] : reg_wdata[1];
    assign clr_mask   = (clr_we_pq[0][p] ? reg_wdata[0] : '0) |
                        (clr_we_pq[1][p] ? reg_wdata[1] : '0);
    sema_notify #(.NUM_GATES(NUM_GATES)) u_ntf (
      .clk(clk), .rst_n(rst_n_int),
      .fail(fail_pg[p]), .released(released), .acquired(acq_pg[p]),
      .ine_we(ine_we_any), .ine_wdata(ine_wd), .clr_mask(clr_mask),
      .ine(ine[p]), .ntf(ntf[p]), .irq(irq[p])
    );
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
      rsp_err   <= '0;
    end else begin
      rsp_valid <= bus_req;
      for (int p = 0; p < NPROC; p++) begin
        if (bus_req[p]) begin
          rsp_rdata[p] <= rdata_c[p];
          rsp_err[p]   <= err_c[p];
        end else begin
          rsp_err[p]   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sema_gate_bank_chk.sv
module sema_gate_bank_chk #(
  parameter int NUM_GATES = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    bus_req,
  input logic [1:0]                    rsp_valid,
  input logic [1:0]                    rsp_err,
  input logic [1:0]                    irq,
  input logic [NUM_GATES-1:0][1:0]     gate_state,
  input logic [1:0][NUM_GATES-1:0]     ine,
  input logic [1:0][NUM_GATES-1:0]     ntf
);
  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
      gate_state[g] != 2'b11);

    // R2: ownership never passes straight from one processor to the other
    p_handover_via_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_state[g] != $past(gate_state[g])) |->
        (gate_state[g] == 2'b00 || $past(gate_state[g]) == 2'b00));

    for (genvar p = 0; p < 2; p++) begin : g_p
      p_notify_on_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ntf[p][g]) |-> (gate_state[g] == 2'b00));
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    p_err_no_gate_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_err[p] && !$past(bus_req[1-p])) |-> (gate_state == $past(gate_state)));

    p_rsp_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req[p] |=> rsp_valid[p]);

    p_no_rsp_without_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req[p] |=> !rsp_valid[p]);

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq[p] |-> (|ine[p] && |ntf[p]));
  end
endmodule

bind sema_gate_bank sema_gate_bank_chk #(.NUM_GATES(NUM_GATES)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .bus_req(bus_req), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .irq(irq), .gate_state(gate_state), .ine(ine), .ntf(ntf)
);

// File: tb/sema_gate_bank_test.sv
`timescale 1ns/1ps
module sema_gate_bank_test;
  logic             clk;
  logic             rst_n;
  logic [1:0]       bus_req, bus_we;
  logic [1:0][7:0]  bus_addr;
  logic [1:0][1:0]  bus_size;
  logic [1:0][31:0] bus_wdata;
  logic [1:0]       rsp_valid, rsp_err, irq;
  logic [1:0][31:0] rsp_rdata;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int cur [16];

  logic [31:0] got_rd;
  logic        got_err, got_vld;

  sema_gate_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic access(input int p, input bit we, input logic [7:0] a,
                        input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_req[p] = 1'b1; bus_we[p] = we; bus_addr[p] = a;
    bus_size[p] = sz;  bus_wdata[p] = d;
    @(posedge clk); #1;
    got_rd = rsp_rdata[p]; got_err = rsp_err[p]; got_vld = rsp_valid[p];
    bus_req[p] = 1'b0; bus_we[p] = 1'b0;
  endtask

  task automatic bwrite(input int p, input int g, input int code);
    access(p, 1'b1, 8'(g), 2'd0, 32'(code) << (8 * (g % 4)));
  endtask

  task automatic bread(input int g);
    access(0, 1'b0, 8'(g), 2'd0, 32'h0);
  endtask

  function automatic int nxt(input int s, input int p, input int d);
    int own;
    own = (p == 0) ? 1 : 2;
    if (d == own && s == 0) return own;
    if (d == 0 && s == own) return 0;
    return s;
  endfunction

  task automatic set_gate(input int g, input int s);
    if (cur[g] != 0) bwrite((cur[g] == 1) ? 0 : 1, g, 0);
    if (s != 0) bwrite((s == 1) ? 0 : 1, g, s);
    cur[g] = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R12: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bus_req = '0; bus_we = '0; bus_addr = '0; bus_size = '0; bus_wdata = '0;
    rst_n = 1'b0;
    foreach (cur[i]) cur[i] = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R6: reset state
    for (int w = 0; w < 4; w++) begin
      access(0, 1'b0, 8'(4*w), 2'd2, 32'h0);
      chk("R6 gates free after reset", got_rd, 32'h0);
    end
    access(1, 1'b0, 8'h40, 2'd2, 32'h0); chk("R6 enable0 zero", got_rd, 32'h0);
    access(1, 1'b0, 8'h48, 2'd2, 32'h0); chk("R6 enable1 zero", got_rd, 32'h0);
    access(0, 1'b0, 8'h80, 2'd2, 32'h0); chk("R6 request0 zero", got_rd, 32'h0);
    chk("R6 irq low", 32'(irq), 32'h0);

    // R12: response timing
    access(0, 1'b0, 8'h00, 2'd0, 32'h0);
    chk("R12 rsp_valid one cycle after req", 32'(got_vld), 32'h1);
    @(posedge clk); #1;
    chk("R12 rsp_valid drops without req", 32'(rsp_valid[0]), 32'h0);

    // R1 R2: sweep every gate, start state, port and written code
    for (int g = 0; g < 16; g++) begin
      for (int s = 0; s < 3; s++) begin
        for (int p = 0; p < 2; p++) begin
          for (int d = 0; d < 4; d++) begin
            int e;
            set_gate(g, s);
            bwrite(p, g, d);
            chk("R2 byte write no error", 32'(got_err), 32'h0);
            e = nxt(s, p, d);
            cur[g] = e;
            bread(g);
            chk("R1 R2 gate code after byte write", got_rd, 32'(e) << (8 * (g % 4)));
          end
        end
      end
      // drain any pending/notify state for this gate
      set_gate(g, 0);
      bwrite(0, g, 1); bwrite(0, g, 0);
      bwrite(1, g, 2); bwrite(1, g, 0);
    end
    access(0, 1'b1, 8'h80, 2'd2, 32'h0000FFFF);
    access(1, 1'b1, 8'h88, 2'd2, 32'h0000FFFF);
    access(0, 1'b0, 8'h80, 2'd2, 32'h0); chk("R10 request0 cleared by write-one", got_rd, 32'h0);
    access(0, 1'b0, 8'h88, 2'd2, 32'h0); chk("R10 request1 cleared by write-one", got_rd, 32'h0);

    // R3: wide reads
    set_gate(0, 1); set_gate(1, 2); set_gate(3, 1);
    access(1, 1'b0, 8'h00, 2'd2, 32'h0); chk("R3 word read of gates 0-3", got_rd, 32'h01000201);
    access(1, 1'b0, 8'h02, 2'd1, 32'h0); chk("R3 half read upper lanes", got_rd, 32'h01000000);
    access(1, 1'b0, 8'h00, 2'd1, 32'h0); chk("R3 half read lower lanes", got_rd, 32'h00000201);
    access(1, 1'b0, 8'h01, 2'd0, 32'h0); chk("R3 byte read lane 1", got_rd, 32'h00000200);
    set_gate(0, 0); set_gate(1, 0); set_gate(3, 0);

    // R4: wide write touching one gate is accepted
    access(1, 1'b1, 8'h04, 2'd2, 32'h01000203);
    chk("R4 single-change word write no error", 32'(got_err), 32'h0);
    cur[5] = 2;
    access(0, 1'b0, 8'h04, 2'd2, 32'h0); chk("R4 only gate 5 taken", got_rd, 32'h00000200);
    // R4: two changes -> error, nothing changes
    access(0, 1'b1, 8'h08, 2'd2, 32'h03030101);
    chk("R4 multi-change word write error", 32'(got_err), 32'h1);
    access(0, 1'b0, 8'h08, 2'd2, 32'h0); chk("R4 no gate changed on error", got_rd, 32'h0);
    access(0, 1'b1, 8'h0A, 2'd1, 32'h01010000);
    chk("R4 multi-change half write error", 32'(got_err), 32'h1);
    access(0, 1'b1, 8'h0A, 2'd1, 32'h03010000);
    chk("R4 single-change half write ok", 32'(got_err), 32'h0);
    access(0, 1'b0, 8'h08, 2'd2, 32'h0); chk("R4 gate 10 taken by half write", got_rd, 32'h00010000);
    cur[10] = 1; set_gate(10, 0);

    // R5: misaligned, bad size, byte to notification register
    access(0, 1'b1, 8'h01, 2'd1, 32'h00000100);
    chk("R5 misaligned half error", 32'(got_err), 32'h1);
    access(0, 1'b0, 8'h02, 2'd2, 32'h0);
    chk("R5 misaligned word error", 32'(got_err), 32'h1);
    chk("R5 misaligned read data zero", got_rd, 32'h0);
    access(0, 1'b1, 8'h00, 2'd3, 32'h00000001);
    chk("R5 size 3 error", 32'(got_err), 32'h1);
    access(0, 1'b0, 8'h00, 2'd2, 32'h0); chk("R5 no gate change from bad writes", got_rd, 32'h0);
    access(0, 1'b1, 8'h40, 2'd0, 32'h000000FF);
    chk("R5 byte to enable register error", 32'(got_err), 32'h1);
    access(0, 1'b0, 8'h40, 2'd2, 32'h0); chk("R5 enable unchanged", got_rd, 32'h0);

    // R7: enable register width
    access(0, 1'b1, 8'h40, 2'd2, 32'hFFFFFFFF);
    access(0, 1'b0, 8'h40, 2'd2, 32'h0); chk("R7 upper enable bits read zero", got_rd, 32'h0000FFFF);
    access(0, 1'b0, 8'h42, 2'd1, 32'h0); chk("R7 upper half reads zero", got_rd, 32'h0);
    access(1, 1'b1, 8'h48, 2'd1, 32'h0000A5C3);
    access(0, 1'b0, 8'h48, 2'd2, 32'h0); chk("R7 enable1 at 0x48", got_rd, 32'h0000A5C3);
    access(0, 1'b1, 8'h40, 2'd1, 32'h0);
    access(1, 1'b1, 8'h48, 2'd1, 32'h0);

    // R8 R9 R10: notify after failed attempt (gate 5 owned by P1)
    bwrite(0, 5, 1);
    bread(5); chk("R2 failed lock leaves owner", got_rd, 32'h00000200);
    access(0, 1'b0, 8'h80, 2'd2, 32'h0); chk("R8 no request before release", got_rd, 32'h0);
    bwrite(1, 5, 0); cur[5] = 0;
    chk("R9 irq low while disabled", 32'(irq[0]), 32'h0);
    access(0, 1'b0, 8'h80, 2'd2, 32'h0); chk("R8 request bit 5 set", got_rd, 32'h00000020);
    access(0, 1'b1, 8'h40, 2'd1, 32'h00000020);
    chk("R9 irq high once enabled", 32'(irq[0]), 32'h1);
    chk("R9 other irq low", 32'(irq[1]), 32'h0);
    access(0, 1'b1, 8'h80, 2'd2, 32'h00000020);
    chk("R10 write-one clears request, irq low", 32'(irq[0]), 32'h0);
    access(0, 1'b0, 8'h80, 2'd2, 32'h0); chk("R10 request cleared", got_rd, 32'h0);

    set_gate(9, 2);
    bwrite(0, 9, 1);
    bwrite(1, 9, 0); cur[9] = 0;
    access(0, 1'b1, 8'h40, 2'd1, 32'h00000200);
    chk("R9 irq for gate 9", 32'(irq[0]), 32'h1);
    bwrite(0, 9, 1); cur[9] = 1;
    chk("R10 lock clears request, irq low", 32'(irq[0]), 32'h0);
    access(0, 1'b0, 8'h80, 2'd2, 32'h0); chk("R10 request cleared by lock", got_rd, 32'h0);
    set_gate(9, 0);
    access(0, 1'b1, 8'h40, 2'd1, 32'h0);

    // R11: simultaneous lock of free gate 7
    @(negedge clk);
    bus_req = 2'b11; bus_we = 2'b11; bus_addr[0] = 8'h07; bus_addr[1] = 8'h07;
    bus_size[0] = 2'd0; bus_size[1] = 2'd0;
    bus_wdata[0] = 32'h01000000; bus_wdata[1] = 32'h02000000;
    @(posedge clk); #1;
    bus_req = 2'b00; bus_we = 2'b00;
    chk("R11 no error on contention", 32'(rsp_err), 32'h0);
    bread(7); chk("R11 processor 0 wins", got_rd, 32'h01000000);
    bwrite(0, 7, 0);
    access(0, 1'b0, 8'h88, 2'd2, 32'h0); chk("R11 loser recorded as failed", got_rd, 32'h00000080);
    access(1, 1'b1, 8'h88, 2'd2, 32'h00000080);
    access(1, 1'b0, 8'h88, 2'd2, 32'h0); chk("R10 loser request cleared", got_rd, 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule